// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable slave that answers a three-wire serial EEPROM protocol. It holds words of `DATA_W` bits in an internal register array. A host drives chip select, a serial clock and a serial data input. The block answers on a serial data output, and a separate enable marks the times when that output would otherwise float. All three pins are sampled on the system clock, so both serial clock edges are seen as events in that clock domain.

Every command opens with a 1 start bit. A 2-bit opcode follows, then an address field one bit wider than the word address; its top bit is don't-care. Reads stream words without a break and wrap around the array. Writes and erases take effect when chip select falls. A busy period follows, counted in system clocks, and a selected device reports that period on the data output. Extended commands raise or lower a write-enable latch.

Top module: `sereeprom_x16`

## Requirements
- R1: After reset the output enable is low and the write-enable latch is cleared, so a WRITE issued before any enable command launches nothing and shows no status.
- R2: A command is a 1 start bit, then an opcode (READ=10, WRITE=01, ERASE=11, extended=00), then an `ADDR_W+1`-bit address field, sent MSB first and sampled on the rising serial clock edge. The address field's top bit has no effect on the word addressed.
- R3: On READ, the output is enabled after the last address bit and shows one 0 dummy bit. The addressed word then follows MSB first, one bit per rising serial clock edge.
- R4: While chip select stays high, the next word follows the last bit at once with no dummy bit. The address wraps from the last word back to 0.
- R5: WRITE takes `DATA_W` data bits, MSB first, after the address. The word is stored when chip select falls after the final data bit. It replaces the old contents without a prior erase.
- R6: An extended command whose address field has top two bits 11 sets write enable, and one with 00 clears it. While it is cleared, WRITE and ERASE change nothing and start no busy period.
- R7: ERASE sets the addressed word to all ones when chip select falls.
- R8: For `BUSY_CYCLES` system clocks after a store launches, a selected device drives 0 with the output enabled. After that it drives 1.
- R9: Shifting a 1 into the data input while status is shown disables the output after the next falling serial clock edge.
- R10: A command whose first bit arrives during the busy period is ignored until chip select falls. It produces no read output and changes no memory.
- R11: Dropping chip select before a command is complete aborts it without changing memory or starting a busy period.
- R12: The output enable stays low while chip select is low and while command, address and write-data bits are shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data input |
| dout | output | 1 | Serial data output (read data or ready/busy) |
| dout_oe | output | 1 | High when dout is driven; low models high impedance |

## Verification
The bench builds the block with a 4-bit word address (16 words, 5-bit address field), 16-bit words and a 200-cycle busy period. The small array lets one streamed read cover every word and cross the wrap point. The short busy period lets the bench watch both busy and ready within a single selection. It also makes it possible to send a whole ignored command while busy, which outlasts the busy window.

// File: rtl/sereeprom_x16.sv
module sereeprom_x16 #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  localparam int AF    = ADDR_W + 1;
  localparam int CMDB  = AF + 2;
  localparam int WORDS = 1 << ADDR_W;
  localparam int CMAX  = (CMDB > DATA_W) ? CMDB : DATA_W;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int BCW   = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WDATA, S_READ, S_ARM, S_HOLD} st_t;

  st_t st;
  logic cs_r, sk_r, di_r, cs_d, sk_d;
  logic [CW-1:0] cnt;
  logic [CMDB-2:0] sh;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wbuf, obuf;
  logic dbit, erase, wen, stat_en, clr_pend;
  logic [BCW-1:0] bcnt;
  logic [DATA_W-1:0] mem [WORDS];

  wire sk_rise = sk_r & ~sk_d;
  wire sk_fall = ~sk_r & sk_d;
  wire cs_fall = cs_d & ~cs_r;
  wire busy    = bcnt != '0;
  wire mem_we  = cs_fall && st == S_ARM && wen;

  wire [CMDB-1:0]   cmd_nx  = {sh, di_r};
  wire [1:0]        op_nx   = cmd_nx[CMDB-1:CMDB-2];
  wire [1:0]        top_nx  = cmd_nx[AF-1:AF-2];
  wire [ADDR_W-1:0] addr_nx = cmd_nx[ADDR_W-1:0];
  wire [ADDR_W-1:0] raddr_n = raddr + 1'b1;

  assign dout    = (st == S_READ) ? dbit : ~busy;
  assign dout_oe = cs_r & ((st == S_READ) | stat_en);

  always_ff @(posedge clk)
    if (mem_we) mem[waddr] <= erase ? '1 : wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_r <= 1'b0; sk_r <= 1'b0; di_r <= 1'b0; cs_d <= 1'b0; sk_d <= 1'b0;
      st <= S_IDLE; cnt <= '0; sh <= '0; waddr <= '0; raddr <= '0;
      wbuf <= '0; obuf <= '0; dbit <= 1'b0; erase <= 1'b0;
      wen <= 1'b0; stat_en <= 1'b0; clr_pend <= 1'b0; bcnt <= '0;
    end else begin
      cs_r <= cs; sk_r <= sk; di_r <= di; cs_d <= cs_r; sk_d <= sk_r;
      if (busy) bcnt <= bcnt - 1'b1;
      if (mem_we) begin
        bcnt    <= BCW'(BUSY_CYCLES);
        stat_en <= 1'b1;
      end
      if (!cs_r) begin
        st       <= S_IDLE;
        clr_pend <= 1'b0;
      end else begin
        if (sk_rise && stat_en && di_r) clr_pend <= 1'b1;
        if (sk_fall && clr_pend) begin
          stat_en  <= 1'b0;
          clr_pend <= 1'b0;
        end
        if (sk_rise) begin
          case (st)
            S_IDLE: begin
              if (busy) st <= S_HOLD;
              else if (di_r) begin
                st  <= S_CMD;
                cnt <= '0;
              end
            end
            S_CMD: begin
              sh  <= cmd_nx[CMDB-2:0];
              cnt <= cnt + 1'b1;
              if (cnt == CW'(CMDB - 1)) begin
                cnt <= '0;
                case (op_nx)
                  2'b10: begin
                    st    <= S_READ;
                    raddr <= addr_nx;
                    obuf  <= mem[addr_nx];
                    dbit  <= 1'b0;
                  end
                  2'b01: begin
                    st    <= S_WDATA;
                    waddr <= addr_nx;
                    erase <= 1'b0;
                  end
                  2'b11: begin
                    st    <= S_ARM;
                    waddr <= addr_nx;
                    erase <= 1'b1;
                  end
                  default: begin
                    if (top_nx == 2'b11) wen <= 1'b1;
                    else if (top_nx == 2'b00) wen <= 1'b0;
                    st <= S_HOLD;
                  end
                endcase
              end
            end
            S_WDATA: begin
              wbuf <= {wbuf[DATA_W-2:0], di_r};
              cnt  <= cnt + 1'b1;
              if (cnt == CW'(DATA_W - 1)) st <= S_ARM;
            end
            S_READ: begin
              dbit <= obuf[DATA_W-1];
              if (cnt == CW'(DATA_W - 1)) begin
                raddr <= raddr_n;
                obuf  <= mem[raddr_n];
                cnt   <= '0;
              end else begin
                obuf <= obuf << 1;
                cnt  <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_quiet_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == S_IDLE || st == S_HOLD));

  assert_launch_only_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);

  assert_launch_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy);

  assert_dummy_zero_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && $past(st) != S_READ) |-> !dbit);

  assert_status_drop_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_en) |-> $past(sk_fall));

  assert_abort_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_r && $past(!cs_r)) |-> st == S_IDLE);
endmodule

// File: tb/test_sereeprom_x16.sv
module test_sereeprom_x16;
  localparam int AW = 4, DW = 16, BC = 200, AF = AW + 1, N = 1 << AW;

  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0;
  logic dout, dout_oe;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  sereeprom_x16 #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BC)) i_sereeprom_x16 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout), .dout_oe(dout_oe));

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'((a * 32'h1357 + s * 32'h0F1D) ^ 32'hA5C3);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o, output logic e);
    di = b;
    repeat (5) @(negedge clk);
    sk = 1;
    repeat (5) @(negedge clk);
    o = dout; e = dout_oe;
    sk = 0;
  endtask

  task automatic send(input int n, input logic [63:0] v, output bit anyoe);
    logic o, e;
    anyoe = 0;
    for (int i = n - 1; i >= 0; i--) begin
      sbit(v[i], o, e);
      if (e && i != n - 1) anyoe = 1;
    end
  endtask

  task automatic sel;
    cs = 1; repeat (4) @(negedge clk);
  endtask

  task automatic desel;
    cs = 0; di = 0; repeat (4) @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    bit z;
    sel;
    send(3 + AF + DW, {3'b101, AF'(a), d}, z);
    chk(!z, "R12 oe during write shift", 32'(z), 0);
    desel;
    repeat (BC + 20) @(negedge clk);
  endtask

  task automatic ext(logic [1:0] top);
    bit z;
    sel;
    send(3 + AF, {3'b100, top, (AF-2)'(0)}, z);
    desel;
  endtask

  task automatic erase(int a);
    bit z;
    sel;
    send(3 + AF, {3'b111, AF'(a)}, z);
    desel;
    repeat (BC + 20) @(negedge clk);
  endtask

  task automatic rd(logic [AF-1:0] af, int n, int a0, string req);
    bit z;
    logic o, e;
    logic [DW-1:0] w;
    sel;
    send(2 + AF, {3'b110, af[AF-1:1]}, z);
    chk(!z, "R12 oe during read command", 32'(z), 0);
    sbit(af[0], o, e);
    chk(e && !o, "R3 dummy zero", {e, o}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < DW; b++) begin
        sbit(1'b0, o, e);
        w = {w[DW-2:0], o};
      end
      chk(w == model[(a0 + k) % N], req, w, model[(a0 + k) % N]);
    end
    desel;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit z;
    logic o, e;
    repeat (5) @(negedge clk);
    chk(!dout_oe, "R1 oe in reset", 32'(dout_oe), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!dout_oe, "R12 oe while deselected", 32'(dout_oe), 0);

    wr(0, 16'h1234);
    sel;
    chk(!dout_oe, "R1 write disabled after reset", 32'(dout_oe), 0);
    desel;

    ext(2'b11);
    for (int a = 0; a < N; a++) begin
      wr(a, pat(a, 0));
      model[a] = pat(a, 0);
    end
    rd(AF'(0), N + 1, 0, "R4 sequential sweep with wrap");
    rd(AF'(N - 2), 4, N - 2, "R4 wrap from last word");
    rd({1'b1, AW'(5)}, 1, 5, "R2 address MSB ignored");

    wr(2, pat(2, 1)); model[2] = pat(2, 1);
    rd(AF'(2), 1, 2, "R5 overwrite without erase");

    sel;
    send(3 + AF + DW, {3'b101, AF'(6), pat(6, 1)}, z);
    cs = 0; repeat (3) @(negedge clk);
    cs = 1; repeat (4) @(negedge clk);
    chk(dout_oe && !dout, "R8 busy shows 0", {dout_oe, dout}, 2'b10);
    repeat (BC) @(negedge clk);
    chk(dout_oe && dout, "R8 ready shows 1", {dout_oe, dout}, 2'b11);
    sbit(1'b1, o, e);
    repeat (4) @(negedge clk);
    chk(!dout_oe, "R9 status cleared by 1", 32'(dout_oe), 0);
    desel;
    model[6] = pat(6, 1);
    rd(AF'(6), 1, 6, "R5 stored on deselect");

    sel;
    send(3 + AF + DW, {3'b101, AF'(7), pat(7, 2)}, z);
    desel;
    sel;
    send(3 + AF + DW, {3'b101, AF'(8), pat(8, 2)}, z);
    chk(!z, "R10 no output for command while busy", 32'(z), 0);
    desel;
    repeat (BC + 20) @(negedge clk);
    model[7] = pat(7, 2);
    rd(AF'(7), 2, 7, "R10 busy write ignored, prior write kept");

    erase(5); model[5] = '1;
    rd(AF'(5), 1, 5, "R7 erase to ones");

    sel;
    send(3 + AF + 8, {3'b101, AF'(9), 8'h5A}, z);
    desel;
    repeat (BC + 20) @(negedge clk);
    sel;
    chk(!dout_oe, "R11 aborted command no busy", 32'(dout_oe), 0);
    desel;
    rd(AF'(9), 1, 9, "R11 aborted write left word");

    ext(2'b00);
    wr(3, pat(3, 3));
    sel;
    chk(!dout_oe, "R6 disabled write no status", 32'(dout_oe), 0);
    desel;
    erase(4);
    rd(AF'(3), 2, 3, "R6 disabled write and erase ignored");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule